// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block watches the occupancy of the transmit and receive byte FIFOs of a serial peripheral controller and turns it into software-visible events. The receive side raises a "ready" event once enough bytes have arrived; the transmit side raises a "request" event once the queue has drained low enough to be refilled. Two more events latch pulses from the serial engine: a receive overflow and the end of a transfer. Each event sits in a status register that software clears by writing ones, so a handler can drain or refill a FIFO first and only then acknowledge. An enable register masks the events onto one interrupt line.

A control word holds both 8-bit trigger levels and two self-clearing FIFO flush commands. A flush of the receive FIFO also discards any pending overflow event. The FIFO storage and the serial engine live outside; they supply the counts and the event pulses and consume the flush pulses.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: Status bit 0 (receive ready) is 1 at the clock edge after any cycle in which `rx_count` is greater than or equal to the receive trigger level held in control bits [7:0].
- R2: Status bit 4 (transmit request) is 1 at the clock edge after any cycle in which `tx_count` is less than or equal to the transmit trigger level held in control bits [23:16].
- R3: A one-cycle pulse on `rx_ovf_evt` sets status bit 8 and a pulse on `xfer_done_evt` sets status bit 12; both stay set until cleared.
- R4: With `sts_we` high, each one in `sts_wdata` clears the matching status bit and each zero leaves it unchanged, so all ones clears everything; a condition or pulse present in the clearing cycle keeps its bit set.
- R5: The enable register uses bits 0, 4, 8 and 12 like the status register, all other bits read 0, and `irq` is 1 exactly when some status bit and its enable are both 1.
- R6: A control write with bit 15 set gives a single-cycle `rx_fifo_rst` pulse in the cycle after the write, and bit 31 likewise gives `tx_fifo_rst`; both bits read back as 0 in `ctl_word` while the trigger fields read back as written.
- R7: The receive flush clears status bit 8 at the edge its pulse begins, even if an overflow pulse arrives in the write cycle; a transmit flush leaves bit 8 alone.
- R8: `occ_word` carries `rx_count` in bits [CNT_W-1:0] and `tx_count` in bits [16+CNT_W-1:16], all other bits 0.
- R9: In reset every status, enable, trigger and flush bit is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_ovf_evt | input | 1 | Receive overflow pulse |
| xfer_done_evt | input | 1 | Transfer complete pulse |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| sts_we | input | 1 | Status clear strobe |
| sts_wdata | input | 32 | Status write-one-to-clear mask |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 32 | Enable register write data |
| ctl_word | output | 32 | Control word readback |
| sts_word | output | 32 | Status register readback |
| ien_word | output | 32 | Enable register readback |
| occ_word | output | 32 | Packed FIFO occupancy |
| rx_fifo_rst | output | 1 | Receive FIFO flush pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO flush pulse |
| irq | output | 1 | Interrupt line |

## Verification
The hardest state to reach is a clear racing a set: a level condition, an overflow pulse and a receive flush all landing in the same cycle as a status write. The stimulus drives the clearing write together with chosen counts and pulses, so every one of the sixteen status patterns is built in one cycle against all sixteen enable masks, and the flush is issued in the very cycle an overflow pulse arrives. The threshold comparisons are swept over every count from empty to full against every trigger level up to just past the depth.

// File: rtl/fti_pkg.sv
package fti_pkg;

    localparam int NUM_EVT    = 4;
    localparam int EVT_STRIDE = 4;
    localparam int TRIG_W     = 8;

    // event index i lives at status/enable bit EVT_STRIDE*i
    localparam int EV_RX_RDY  = 0;
    localparam int EV_TX_REQ  = 1;
    localparam int EV_RX_OVF  = 2;
    localparam int EV_DONE    = 3;

    localparam int RX_TRIG_LSB = 0;
    localparam int TX_TRIG_LSB = 16;
    localparam int RX_RST_BIT  = 15;
    localparam int TX_RST_BIT  = 31;
    localparam int TX_CNT_LSB  = 16;

    function automatic logic [31:0] spread_evt(input logic [NUM_EVT-1:0] e);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            w[EVT_STRIDE*i] = e[i];
        end
        return w;
    endfunction

    function automatic logic [NUM_EVT-1:0] gather_evt(input logic [31:0] w);
        logic [NUM_EVT-1:0] e;
        for (int i = 0; i < NUM_EVT; i++) begin
            e[i] = w[EVT_STRIDE*i];
        end
        return e;
    endfunction

endpackage

// File: rtl/fti_level_cmp.sv
module fti_level_cmp #(
    parameter int CNT_W  = 7,
    parameter int TRIG_W = 8
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [TRIG_W-1:0] tx_trig,
    output logic              rx_hit,
    output logic              tx_hit
);
    localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W;

    logic [CMP_W-1:0] rx_c, tx_c, rx_t, tx_t;

    always_comb begin
        rx_c   = CMP_W'(rx_count);
        tx_c   = CMP_W'(tx_count);
        rx_t   = CMP_W'(rx_trig);
        tx_t   = CMP_W'(tx_trig);
        rx_hit = (rx_c >= rx_t);
        tx_hit = (tx_c <= tx_t);
    end
endmodule

// File: rtl/fti_ctl_reg.sv
module fti_ctl_reg #(
    parameter int TRIG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [TRIG_W-1:0] rx_trig_w,
    input  logic [TRIG_W-1:0] tx_trig_w,
    input  logic              rx_flush_w,
    input  logic              tx_flush_w,
    output logic [TRIG_W-1:0] rx_trig,
    output logic [TRIG_W-1:0] tx_trig,
    output logic              rx_flush,
    output logic              tx_flush
);
    typedef struct packed {
        logic [TRIG_W-1:0] rx_trig;
        logic [TRIG_W-1:0] tx_trig;
        logic              rx_flush;
        logic              tx_flush;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rx_flush = 1'b0;
        st_d.tx_flush = 1'b0;
        if (we) begin
            st_d.rx_trig  = rx_trig_w;
            st_d.tx_trig  = tx_trig_w;
            st_d.rx_flush = rx_flush_w;
            st_d.tx_flush = tx_flush_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_trig  = st_q.rx_trig;
    assign tx_trig  = st_q.tx_trig;
    assign rx_flush = st_q.rx_flush;
    assign tx_flush = st_q.tx_flush;
endmodule

// File: rtl/fti_status_bank.sv
module fti_status_bank
    import fti_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_evt,
    input  logic               clr_we,
    input  logic [NUM_EVT-1:0] clr_mask,
    input  logic               ien_we,
    input  logic [NUM_EVT-1:0] ien_w,
    input  logic               ovf_flush,
    output logic [NUM_EVT-1:0] sts,
    output logic [NUM_EVT-1:0] ien,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_EVT-1:0] sts;
        logic [NUM_EVT-1:0] ien;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_EVT-1:0] clr_eff;

    always_comb begin
        st_d    = st_q;
        clr_eff = clr_we ? clr_mask : '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            st_d.sts[i] = (st_q.sts[i] & ~clr_eff[i]) | set_evt[i];
        end
        if (ovf_flush) begin
            st_d.sts[EV_RX_OVF] = 1'b0;
        end
        if (ien_we) begin
            st_d.ien = ien_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign ien = st_q.ien;
    assign irq = |(st_q.sts & st_q.ien);
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
    import fti_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_ovf_evt,
    input  logic             xfer_done_evt,
    input  logic             ctl_we,
    input  logic [31:0]      ctl_wdata,
    input  logic             sts_we,
    input  logic [31:0]      sts_wdata,
    input  logic             ien_we,
    input  logic [31:0]      ien_wdata,
    output logic [31:0]      ctl_word,
    output logic [31:0]      sts_word,
    output logic [31:0]      ien_word,
    output logic [31:0]      occ_word,
    output logic             rx_fifo_rst,
    output logic             tx_fifo_rst,
    output logic             irq
);
    logic [TRIG_W-1:0]  rx_trig, tx_trig;
    logic               rx_hit, tx_hit;
    logic [NUM_EVT-1:0] set_evt, sts, ien;

    fti_ctl_reg #(.TRIG_W(TRIG_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (ctl_we),
        .rx_trig_w  (ctl_wdata[RX_TRIG_LSB +: TRIG_W]),
        .tx_trig_w  (ctl_wdata[TX_TRIG_LSB +: TRIG_W]),
        .rx_flush_w (ctl_wdata[RX_RST_BIT]),
        .tx_flush_w (ctl_wdata[TX_RST_BIT]),
        .rx_trig    (rx_trig),
        .tx_trig    (tx_trig),
        .rx_flush   (rx_fifo_rst),
        .tx_flush   (tx_fifo_rst)
    );

    fti_level_cmp #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_cmp (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_trig  (rx_trig),
        .tx_trig  (tx_trig),
        .rx_hit   (rx_hit),
        .tx_hit   (tx_hit)
    );

    always_comb begin
        set_evt            = '0;
        set_evt[EV_RX_RDY] = rx_hit;
        set_evt[EV_TX_REQ] = tx_hit;
        set_evt[EV_RX_OVF] = rx_ovf_evt;
        set_evt[EV_DONE]   = xfer_done_evt;
    end

    // a flush command written this cycle clears overflow at the edge its pulse starts
    fti_status_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (set_evt),
        .clr_we    (sts_we),
        .clr_mask  (gather_evt(sts_wdata)),
        .ien_we    (ien_we),
        .ien_w     (gather_evt(ien_wdata)),
        .ovf_flush (ctl_we & ctl_wdata[RX_RST_BIT]),
        .sts       (sts),
        .ien       (ien),
        .irq       (irq)
    );

    always_comb begin
        ctl_word                             = '0;
        ctl_word[RX_TRIG_LSB +: TRIG_W]      = rx_trig;
        ctl_word[TX_TRIG_LSB +: TRIG_W]      = tx_trig;
        occ_word                             = '0;
        occ_word[0 +: CNT_W]                 = rx_count;
        occ_word[TX_CNT_LSB +: CNT_W]        = tx_count;
        sts_word                             = spread_evt(sts);
        ien_word                             = spread_evt(ien);
    end

    logic unused_wdata;
    assign unused_wdata = ^{ctl_wdata, sts_wdata, ien_wdata};
endmodule

// File: rtl/spi_fifo_irq_ctrl_chk.sv
module spi_fifo_irq_ctrl_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             ctl_we,
    input logic             ctl_rx_flush_bit,
    input logic             sts_we,
    input logic             sts_done_bit,
    input logic [31:0]      ctl_word,
    input logic [31:0]      sts_word,
    input logic [31:0]      ien_word,
    input logic             rx_fifo_rst,
    input logic             irq
);
    localparam int W = (CNT_W > 8) ? CNT_W : 8;

    a_r1_rx_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (W'(rx_count) >= W'(ctl_word[7:0])) |=> sts_word[0]);

    a_r2_tx_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (W'(tx_count) <= W'(ctl_word[23:16])) |=> sts_word[4]);

    a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_word[12] && !(sts_we && sts_done_bit)) |=> sts_word[12]);

    a_r6_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fifo_rst && !(ctl_we && ctl_rx_flush_bit)) |=> !rx_fifo_rst);

    a_r7_flush_drops_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_rst |-> !sts_word[8]);

    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_word == 32'd0) |-> !irq);
endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rx_count         (rx_count),
    .tx_count         (tx_count),
    .ctl_we           (ctl_we),
    .ctl_rx_flush_bit (ctl_wdata[15]),
    .sts_we           (sts_we),
    .sts_done_bit     (sts_wdata[12]),
    .ctl_word         (ctl_word),
    .sts_word         (sts_word),
    .ien_word         (ien_word),
    .rx_fifo_rst      (rx_fifo_rst),
    .irq              (irq)
);

// File: tb/spi_fifo_irq_ctrl_bench.sv
module spi_fifo_irq_ctrl_bench;
    localparam int DEPTH = 64;
    localparam int CW    = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_ovf_evt, xfer_done_evt;
    logic          ctl_we, sts_we, ien_we;
    logic [31:0]   ctl_wdata, sts_wdata, ien_wdata;
    logic [31:0]   ctl_word, sts_word, ien_word, occ_word;
    logic          rx_fifo_rst, tx_fifo_rst, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spi_fifo_irq_ctrl #(.FIFO_DEPTH(DEPTH)) u_spi_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .rx_ovf_evt(rx_ovf_evt), .xfer_done_evt(xfer_done_evt),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
        .ien_we(ien_we), .ien_wdata(ien_wdata), .ctl_word(ctl_word), .sts_word(sts_word),
        .ien_word(ien_word), .occ_word(occ_word), .rx_fifo_rst(rx_fifo_rst),
        .tx_fifo_rst(tx_fifo_rst), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [31:0] ev(input logic [3:0] e);
        return {19'd0, e[3], 3'd0, e[2], 3'd0, e[1], 3'd0, e[0]};
    endfunction

    task automatic write_ctl(input logic [31:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        tick();
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rx_count = '0; tx_count = '0; rx_ovf_evt = 1'b0; xfer_done_evt = 1'b0;
        ctl_we = 1'b0; sts_we = 1'b0; ien_we = 1'b0;
        ctl_wdata = '0; sts_wdata = '0; ien_wdata = '0;
        repeat (3) tick();
        // R9: reset state
        check("R9 status", sts_word, 32'd0);
        check("R9 enable", ien_word, 32'd0);
        check("R9 control", ctl_word, 32'd0);
        check("R9 flush", {30'd0, rx_fifo_rst, tx_fifo_rst}, 32'd0);
        check("R9 irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        tick();

        // R8: occupancy packing
        rx_count = 7'd37; tx_count = 7'd5;
        #1 check("R8 occupancy", occ_word, (32'd5 << 16) | 32'd37);
        rx_count = 7'd64; tx_count = 7'd127;
        #1 check("R8 occupancy", occ_word, (32'd127 << 16) | 32'd64);

        // R1 / R2: full sweep of level against count
        for (int t = 0; t <= DEPTH + 2; t++) begin
            write_ctl((32'(t) << 16) | 32'(t));
            for (int c = 0; c <= DEPTH; c++) begin
                rx_count = CW'(c); tx_count = CW'(c);
                sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF;
                tick();
                sts_we = 1'b0; sts_wdata = '0;
                check("R1 rx ready", {31'd0, sts_word[0]}, {31'd0, c >= t});
                check("R2 tx request", {31'd0, sts_word[4]}, {31'd0, c <= t});
            end
        end

        // quiet levels: rx trig 10 with count 0, tx trig 10 with count 64
        write_ctl((32'd10 << 16) | 32'd10);
        rx_count = 7'd0; tx_count = 7'd64;
        check("R6 trigger readback", ctl_word, (32'd10 << 16) | 32'd10);
        sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF; tick(); sts_we = 1'b0;
        check("R4 all ones clears", sts_word, 32'd0);

        // R3: pulses latch and hold
        rx_ovf_evt = 1'b1; tick(); rx_ovf_evt = 1'b0;
        check("R3 overflow latch", sts_word, 32'h0000_0100);
        xfer_done_evt = 1'b1; tick(); xfer_done_evt = 1'b0;
        repeat (3) tick();
        check("R3 held", sts_word, 32'h0000_1100);

        // R4: zero writes leave, ones clear, set wins
        sts_we = 1'b1; sts_wdata = 32'd0; tick(); sts_we = 1'b0;
        check("R4 zero write", sts_word, 32'h0000_1100);
        sts_we = 1'b1; sts_wdata = 32'h0000_0100; tick(); sts_we = 1'b0;
        check("R4 one clears", sts_word, 32'h0000_1000);
        sts_we = 1'b1; sts_wdata = 32'h0000_1000; xfer_done_evt = 1'b1;
        tick(); sts_we = 1'b0; xfer_done_evt = 1'b0;
        check("R4 set beats clear", sts_word, 32'h0000_1000);
        sts_we = 1'b1; sts_wdata = 32'h0000_1000; tick(); sts_we = 1'b0;
        check("R4 clear done", sts_word, 32'd0);

        // R5: every status pattern against every enable mask
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                rx_count = s[0] ? 7'd64 : 7'd0;
                tx_count = s[1] ? 7'd0 : 7'd64;
                rx_ovf_evt = s[2]; xfer_done_evt = s[3];
                sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF;
                ien_we = 1'b1; ien_wdata = ev(4'(e)) | 32'hEEEE_EEEE;
                tick();
                rx_ovf_evt = 1'b0; xfer_done_evt = 1'b0; sts_we = 1'b0; ien_we = 1'b0;
                check("R5 status pattern", sts_word, ev(4'(s)));
                check("R5 enable readback", ien_word, ev(4'(e)));
                check("R5 irq", {31'd0, irq}, {31'd0, (s & e) != 0});
            end
        end
        rx_count = 7'd0; tx_count = 7'd64;
        ien_we = 1'b1; ien_wdata = '0; tick(); ien_we = 1'b0;
        sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF; tick(); sts_we = 1'b0;

        // R6: flush pulses
        ctl_we = 1'b1; ctl_wdata = 32'h0000_8000 | (32'd10 << 16) | 32'd10; tick();
        ctl_we = 1'b0; ctl_wdata = '0;
        check("R6 rx flush pulse", {30'd0, rx_fifo_rst, tx_fifo_rst}, 32'd2);
        check("R6 flush bit reads 0", ctl_word, (32'd10 << 16) | 32'd10);
        tick();
        check("R6 rx flush ends", {30'd0, rx_fifo_rst, tx_fifo_rst}, 32'd0);
        ctl_we = 1'b1; ctl_wdata = 32'h8000_0000 | (32'd10 << 16) | 32'd10; tick();
        ctl_we = 1'b0; ctl_wdata = '0;
        check("R6 tx flush pulse", {30'd0, rx_fifo_rst, tx_fifo_rst}, 32'd1);
        check("R6 tx bit reads 0", ctl_word, (32'd10 << 16) | 32'd10);
        tick();
        check("R6 tx flush ends", {30'd0, rx_fifo_rst, tx_fifo_rst}, 32'd0);

        // R7: flush clears overflow, wins against a same-cycle pulse
        rx_ovf_evt = 1'b1; tick(); rx_ovf_evt = 1'b0;
        check("R7 ovf set", sts_word, 32'h0000_0100);
        ctl_we = 1'b1; ctl_wdata = 32'h0000_8000 | (32'd10 << 16) | 32'd10;
        rx_ovf_evt = 1'b1; tick();
        ctl_we = 1'b0; ctl_wdata = '0; rx_ovf_evt = 1'b0;
        check("R7 rx flush clears ovf", sts_word, 32'd0);
        rx_ovf_evt = 1'b1; tick(); rx_ovf_evt = 1'b0;
        write_ctl(32'h8000_0000 | (32'd10 << 16) | 32'd10);
        tick();
        check("R7 tx flush keeps ovf", sts_word, 32'h0000_0100);

        finish_run();
    end
endmodule